// File: doc/BRIEF.md
# Lockable Dual-Clock Sample FIFO

This block carries samples from a producer clock domain to a consumer clock domain through sixteen storage slots. After reset the write position sits half the depth ahead of the read position. The FIFO therefore starts with eight samples queued, and the clock ratio can drift by up to eight samples either way before the FIFO overflows or runs dry.

Several copies of the block can run in lockstep. One copy is the leader. It emits a one-cycle pulse from each of its two address counters whenever that counter wraps back to slot zero. Every other copy is a follower. It takes those pulses in and forces the matching local counter back to slot zero, so all copies address the same slots at the same time.

Full and empty are found by comparing Gray-coded pointers that have been carried across domains by two-stage synchronisers. A write into a full FIFO is discarded. A read from an empty FIFO leaves the previous sample on the output. Each of these misuses latches its own error bit until reset.

Top module: `lockable_cdc_fifo`

## Requirements
- R1: After reset, full, empty, both error bits, both zero pulses and rd_data are low. The write pointer leads the read pointer by DEPTH/2, and the storage is cleared, so exactly eight reads of value zero are accepted before empty rises.
- R2: Accepted writes are read back in the order written. rd_data takes the new sample on the read-clock edge that accepts the read, and empty rises once every stored sample has been read.
- R3: full rises once DEPTH samples are held. A write while full stores nothing and moves no pointer, and it sets ovf_err, which stays high until reset.
- R4: A read while empty leaves rd_data and the read pointer unchanged and sets unf_err, which stays high until reset.
- R5: With lead_mode=1, wzero_out is high for exactly one write-clock cycle after each accepted write that moves the write address from DEPTH-1 to 0. rzero_out behaves the same way for reads, in the read-clock domain.
- R6: With lead_mode=1, wzero_in and rzero_in have no effect.
- R7: With lead_mode=0, wzero_out and rzero_out stay low.
- R8: With lead_mode=0, wzero_in is registered on the write clock. On the next write-clock edge the write address becomes 0 and the pointer's lap bit is kept. If a write is accepted on that same edge, its sample is stored at the old address, but the clear wins over the increment.
- R9: With lead_mode=0, rzero_in clears the read address in the same way on the read clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write domain |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read domain |
| lead_mode | input | 1 | 1 = leader, 0 = follower; change only under reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Sample to store |
| wzero_in | input | 1 | Follower: clear the write address |
| wzero_out | output | 1 | Leader: write address wrapped to zero |
| full | output | 1 | No free slot (write domain) |
| ovf_err | output | 1 | Sticky: write while full |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Last sample read |
| rzero_in | input | 1 | Follower: clear the read address |
| rzero_out | output | 1 | Leader: read address wrapped to zero |
| empty | output | 1 | Nothing stored (read domain) |
| unf_err | output | 1 | Sticky: read while empty |

## Verification
The bench drains the eight reset-time samples and then fills all sixteen slots across the wrap point of both counters. If the initial offset were wrong, zeros would be missing or extra. If the wrap detection were wrong, the pulse count would not be exactly one per counter. It pushes one write and pulls one read past the limits. A design that stored the dropped write would put an extra word into the read order, and one that did not hold rd_data would change the output on the empty read. In follower mode it raises the clear input alongside a write, and it raises the read clear while idle. It then reads the data back. A design where the increment beat the clear, or where the clear was ignored, would return zeros instead of the samples written after the clear. Leader mode is also given stray clear pulses, which must leave the data order untouched.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

  // role taken by one copy of the FIFO in a locked group
  typedef enum logic {
    ROLE_FOLLOW = 1'b0,
    ROLE_LEAD   = 1'b1
  } role_e;

  // which side of the FIFO a pointer controller serves
  typedef enum logic {
    SIDE_READ  = 1'b0,
    SIDE_WRITE = 1'b1
  } side_e;

endpackage

// File: rtl/lcf_rst_sync.sv
module lcf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_n;

  assign stage_n = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_n;
    end
  end

  assign rst_n = stage_q[1];

endmodule

// File: rtl/lcf_sync2.sv
module lcf_sync2 #(
  parameter int unsigned    W   = 5,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST;
      hold_q <= RST;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;

endmodule

// File: rtl/lcf_ptr_ctl.sv
module lcf_ptr_ctl
  import lcf_pkg::*;
#(
  parameter int unsigned    AW      = 4,
  parameter side_e          SIDE    = SIDE_WRITE,
  parameter logic [AW:0]    RST_BIN = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  role_e         role,
  input  logic          req,
  input  logic          zero_in,
  input  logic [AW:0]   peer_gray,
  output logic          accept,
  output logic [AW-1:0] addr,
  output logic [AW:0]   gray,
  output logic          status,
  output logic          zero_out,
  output logic          err
);

  localparam logic [AW:0]   RST_GRAY = RST_BIN ^ (RST_BIN >> 1);
  localparam logic [AW-1:0] LAST     = '1;

  logic [AW:0] bin_q, bin_n;
  logic [AW:0] gray_q, gray_n;
  logic        clr_q, clr_n;
  logic        zero_q, zero_n;
  logic        err_q, err_n;
  logic        adv_en;

  // status: full on the write side, empty on the read side
  generate
    if (SIDE == SIDE_WRITE) begin : g_full
      assign status = (gray_q == {~peer_gray[AW:AW-1], peer_gray[AW-2:0]});
    end else begin : g_empty
      assign status = (gray_q == peer_gray);
    end
  endgenerate

  assign accept = req && !status;
  assign adv_en = clr_q || accept;

  always_comb begin
    bin_n = bin_q;
    if (clr_q) begin
      bin_n = {bin_q[AW], {AW{1'b0}}};
    end else if (accept) begin
      bin_n = bin_q + 1'b1;
    end
    gray_n = bin_n ^ (bin_n >> 1);
    clr_n  = (role == ROLE_FOLLOW) && zero_in;
    zero_n = (role == ROLE_LEAD) && !clr_q && accept && (bin_q[AW-1:0] == LAST);
    err_n  = err_q || (req && status);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= RST_BIN;
      gray_q <= RST_GRAY;
    end else if (adv_en) begin
      bin_q  <= bin_n;
      gray_q <= gray_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q  <= 1'b0;
      zero_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      clr_q  <= clr_n;
      zero_q <= zero_n;
      err_q  <= err_n;
    end
  end

  assign addr     = bin_q[AW-1:0];
  assign gray     = gray_q;
  assign zero_out = zero_q;
  assign err      = err_q;

  // wrap pulse lasts one cycle of this domain
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_q |=> !zero_q);

  // a follower never drives its wrap pulse
  assert_follower_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_FOLLOW) |-> !zero_q);

  // a leader never takes an external clear
  assert_leader_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_LEAD) |-> !clr_q);

  // clear beats increment; on the read instance this is R9
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (bin_q[AW-1:0] == '0));

  // refused request leaves the pointer alone; R4 on the read instance
  assert_refused_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && status && !clr_q) |=> $stable(bin_q));

  // misuse sets the error bit and it stays set
  assert_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && status) |=> err_q);
  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

endmodule

// File: rtl/lcf_store.sv
module lcf_store #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] slot_q;
  logic [DW-1:0]            rdata_q;
  logic [DW-1:0]            rdata_n;

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic slot_en;
      assign slot_en = we && (waddr == AW'(e));
      always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
          slot_q[e] <= '0;
        end else if (slot_en) begin
          slot_q[e] <= wdata;
        end
      end
    end
  endgenerate

  assign rdata_n = slot_q[raddr];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= rdata_n;
    end
  end

  assign rdata = rdata_q;

  // output holds when no read is accepted (covers read-while-empty)
  assert_hold_on_idle_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re |=> $stable(rdata_q));

endmodule

// File: rtl/lockable_cdc_fifo.sv
module lockable_cdc_fifo
  import lcf_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          lead_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          wzero_in,
  output logic          wzero_out,
  output logic          full,
  output logic          ovf_err,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          rzero_in,
  output logic          rzero_out,
  output logic          empty,
  output logic          unf_err
);

  localparam int unsigned AW      = $clog2(DEPTH);
  localparam int unsigned PW      = AW + 1;
  localparam logic [PW-1:0] W_RST   = PW'(DEPTH / 2);
  localparam logic [PW-1:0] R_RST   = '0;
  localparam logic [PW-1:0] W_RST_G = W_RST ^ (W_RST >> 1);
  localparam logic [PW-1:0] R_RST_G = R_RST ^ (R_RST >> 1);

  role_e         role;
  logic          w_rst_n, r_rst_n;
  logic          w_acc, r_acc;
  logic [AW-1:0] w_addr, r_addr;
  logic [PW-1:0] w_gray, r_gray;
  logic [PW-1:0] w_gray_in_r, r_gray_in_w;

  assign role = role_e'(lead_mode);

  lcf_rst_sync u_wrst (.clk(wclk), .arst_n(wrst_n), .rst_n(w_rst_n));
  lcf_rst_sync u_rrst (.clk(rclk), .arst_n(rrst_n), .rst_n(r_rst_n));

  lcf_sync2 #(.W(PW), .RST(R_RST_G)) u_r2w (
    .clk(wclk), .rst_n(w_rst_n), .d(r_gray), .q(r_gray_in_w)
  );

  lcf_sync2 #(.W(PW), .RST(W_RST_G)) u_w2r (
    .clk(rclk), .rst_n(r_rst_n), .d(w_gray), .q(w_gray_in_r)
  );

  lcf_ptr_ctl #(.AW(AW), .SIDE(SIDE_WRITE), .RST_BIN(W_RST)) u_wctl (
    .clk      (wclk),
    .rst_n    (w_rst_n),
    .role     (role),
    .req      (wr_en),
    .zero_in  (wzero_in),
    .peer_gray(r_gray_in_w),
    .accept   (w_acc),
    .addr     (w_addr),
    .gray     (w_gray),
    .status   (full),
    .zero_out (wzero_out),
    .err      (ovf_err)
  );

  lcf_ptr_ctl #(.AW(AW), .SIDE(SIDE_READ), .RST_BIN(R_RST)) u_rctl (
    .clk      (rclk),
    .rst_n    (r_rst_n),
    .role     (role),
    .req      (rd_en),
    .zero_in  (rzero_in),
    .peer_gray(w_gray_in_r),
    .accept   (r_acc),
    .addr     (r_addr),
    .gray     (r_gray),
    .status   (empty),
    .zero_out (rzero_out),
    .err      (unf_err)
  );

  lcf_store #(.DW(DW), .AW(AW)) u_store (
    .wclk  (wclk),
    .wrst_n(w_rst_n),
    .we    (w_acc),
    .waddr (w_addr),
    .wdata (wr_data),
    .rclk  (rclk),
    .rrst_n(r_rst_n),
    .re    (r_acc),
    .raddr (r_addr),
    .rdata (rd_data)
  );

  // full and empty never coexist with a refused-yet-accepted request
  assert_no_write_when_full_R3: assert property (@(posedge wclk) disable iff (!w_rst_n)
    full |-> !w_acc);
  assert_no_read_when_empty_R4: assert property (@(posedge rclk) disable iff (!r_rst_n)
    empty |-> !r_acc);

endmodule

// File: tb/lockable_cdc_fifo_tb.sv
module lockable_cdc_fifo_tb_top;

  logic        wclk = 1'b0;
  logic        rclk = 1'b0;
  logic        wrst_n, rrst_n, lead_mode;
  logic        wr_en, wzero_in, rd_en, rzero_in;
  logic [15:0] wr_data;
  logic        wzero_out, full, ovf_err, rzero_out, empty, unf_err;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int wz_cnt = 0;
  int rz_cnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  lockable_cdc_fifo #(.DW(16), .DEPTH(16)) dut_i (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .lead_mode(lead_mode),
    .wr_en(wr_en), .wr_data(wr_data), .wzero_in(wzero_in),
    .wzero_out(wzero_out), .full(full), .ovf_err(ovf_err),
    .rd_en(rd_en), .rd_data(rd_data), .rzero_in(rzero_in),
    .rzero_out(rzero_out), .empty(empty), .unf_err(unf_err)
  );

  always @(negedge wclk) if (wzero_out === 1'b1) wz_cnt++;
  always @(negedge rclk) if (rzero_out === 1'b1) rz_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge wclk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hang expected finish");
      summary();
      $finish;
    end
  end

  // caller stands at a write-clock falling edge
  task automatic wr(input logic [15:0] v, input logic zf);
    wr_en = 1'b1; wr_data = v; wzero_in = zf;
    @(negedge wclk);
    wr_en = 1'b0; wzero_in = 1'b0;
  endtask

  // caller stands at a read-clock falling edge
  task automatic rd(output logic [15:0] v, input logic zf);
    rd_en = 1'b1; rzero_in = zf;
    @(negedge rclk);
    rd_en = 1'b0; rzero_in = 1'b0;
    v = rd_data;
  endtask

  task automatic do_reset(input logic mode);
    wrst_n = 1'b0; rrst_n = 1'b0;
    #1;
    lead_mode = mode;
    wr_en = 1'b0; rd_en = 1'b0; wzero_in = 1'b0; rzero_in = 1'b0; wr_data = '0;
    repeat (4) @(negedge wclk);
    wrst_n = 1'b1;
    @(negedge rclk);
    rrst_n = 1'b1;
    repeat (6) @(negedge rclk);
    repeat (4) @(negedge wclk);
    wz_cnt = 0; rz_cnt = 0;
  endtask

  initial begin
    logic [15:0] got;
    wrst_n = 1'b0; rrst_n = 1'b0; lead_mode = 1'b1;
    wr_en = 1'b0; rd_en = 1'b0; wzero_in = 1'b0; rzero_in = 1'b0; wr_data = '0;

    // ---------------- leader ----------------
    do_reset(1'b1);
    check("R1 full after reset", 32'(full), 0);
    check("R1 ovf_err after reset", 32'(ovf_err), 0);
    check("R1 wzero_out after reset", 32'(wzero_out), 0);
    @(negedge rclk);
    check("R1 empty after reset", 32'(empty), 0);
    check("R1 unf_err after reset", 32'(unf_err), 0);
    check("R1 rd_data after reset", 32'(rd_data), 0);

    for (int i = 0; i < 8; i++) begin
      rd(got, 1'b0);
      check("R1 preloaded sample", 32'(got), 0);
    end
    check("R1 empty after half depth", 32'(empty), 1);
    repeat (2) @(negedge rclk);
    check("R5 no read wrap yet", rz_cnt, 0);

    repeat (4) @(negedge wclk);
    for (int i = 0; i < 16; i++) begin
      wr(16'h0100 + 16'(i), (i == 4));   // stray clear in leader mode: R6
    end
    repeat (4) @(negedge wclk);
    check("R5 one write wrap pulse", wz_cnt, 1);
    check("R3 full at depth", 32'(full), 1);
    wr(16'hDEAD, 1'b0);
    check("R3 ovf_err on write while full", 32'(ovf_err), 1);
    check("R3 full still set", 32'(full), 1);

    repeat (6) @(negedge rclk);
    for (int i = 0; i < 16; i++) begin
      rd(got, (i == 3));                 // stray clear in leader mode: R6
      check((i == 4) ? "R6 order after stray clears" : "R2 read order",
            32'(got), 32'(16'h0100 + 16'(i)));
    end
    check("R2 empty after drain", 32'(empty), 1);
    repeat (2) @(negedge rclk);
    check("R5 one read wrap pulse", rz_cnt, 1);
    rd(got, 1'b0);
    check("R4 rd_data held on empty read", 32'(got), 32'h010F);
    check("R4 unf_err on read while empty", 32'(unf_err), 1);
    check("R4 still empty", 32'(empty), 1);
    repeat (3) @(negedge rclk);
    check("R4 unf_err sticky", 32'(unf_err), 1);
    @(negedge wclk);
    check("R3 ovf_err sticky", 32'(ovf_err), 1);

    // ---------------- follower ----------------
    do_reset(1'b0);
    wr(16'h0201, 1'b0);
    wr(16'h0202, 1'b1);                  // clear registered here
    wr(16'h0203, 1'b0);                  // stored at old slot, pointer -> 0
    wr(16'h0204, 1'b0);
    wr(16'h0205, 1'b0);
    repeat (4) @(negedge wclk);
    check("R7 no write pulse in follower", wz_cnt, 0);
    repeat (6) @(negedge rclk);
    rd(got, 1'b0);
    check("R8 first sample after write clear", 32'(got), 32'h0204);
    rd(got, 1'b0);
    check("R8 second sample after write clear", 32'(got), 32'h0205);
    check("R8 empty after two", 32'(empty), 1);

    repeat (4) @(negedge wclk);
    wr(16'h0206, 1'b0);
    wr(16'h0207, 1'b0);
    wr(16'h0208, 1'b0);
    repeat (6) @(negedge rclk);
    rzero_in = 1'b1;
    @(negedge rclk);
    rzero_in = 1'b0;
    @(negedge rclk);
    repeat (4) @(negedge rclk);
    for (int i = 0; i < 5; i++) begin
      rd(got, 1'b0);
      check("R9 samples after read clear", 32'(got), 32'(16'h0204 + 16'(i)));
    end
    check("R9 empty after replay", 32'(empty), 1);
    repeat (2) @(negedge rclk);
    check("R7 no read pulse in follower", rz_cnt, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule